// File: doc/BRIEF.md
# Operand Forwarding Unit

This block selects the two ALU operands of a five-stage in-order pipeline in the execute stage. Each operand normally comes from the register value captured in the decode/execute pipeline register. When an older instruction still in flight is about to write that source register, the block takes the newer value from that instruction instead. It can come from the execute/memory register, which holds the previous ALU result, or from the memory/write-back register, which holds loaded data or an older ALU result. When both of those stages target the same register, the younger of the two supplies the value.

The block also holds the general-purpose register file used in the decode stage. The write-back stage writes it. A read of a register in the same cycle that register is written returns the new data, so the third instruction after a producer does not need a forwarding path. Register zero is hard-wired to zero. It is never forwarded and never written.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage targets the source register, the select is 00 and the operand equals the decode/execute register value.
- R2: When the execute/memory stage has its write enable set, a nonzero destination, and that destination equals the source register, the select is 10 and the operand equals the execute/memory ALU result.
- R3: When only the memory/write-back stage matches under the same conditions, the select is 01 and the operand equals the write-back value.
- R4: A stage whose write enable is low never supplies an operand, even when its destination matches.
- R5: A stage whose destination is register 0 never supplies an operand.
- R6: When both stages match the same source register, the select is 10, so the execute/memory value wins.
- R7: Operand B applies the same rules to the second source register (rt), independently of operand A, which uses the first (rs).
- R8: A register-file read of a register being written in the same cycle returns the data being written. Later reads return the same data until the register is written again.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: The select code 11 is never produced on either operand.
- R11: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the register file |
| rd_addr_a | input | ADDR_W | Decode-stage read register, port A |
| rd_addr_b | input | ADDR_W | Decode-stage read register, port B |
| rf_rdata_a | output | DATA_W | Register-file read data, port A (with same-cycle bypass) |
| rf_rdata_b | output | DATA_W | Register-file read data, port B (with same-cycle bypass) |
| ex_rs | input | ADDR_W | First source register of the instruction in execute |
| ex_rt | input | ADDR_W | Second source register of the instruction in execute |
| ex_rs_val | input | DATA_W | Register value latched for the first source |
| ex_rt_val | input | DATA_W | Register value latched for the second source |
| mem_wen | input | 1 | Execute/memory stage writes a register |
| mem_rd | input | ADDR_W | Execute/memory destination register |
| mem_alu | input | DATA_W | Execute/memory ALU result |
| wb_wen | input | 1 | Write-back stage writes a register; also the register-file write enable |
| wb_rd | input | ADDR_W | Write-back destination register; also the register-file write address |
| wb_val | input | DATA_W | Write-back value; also the register-file write data |
| fwd_a | output | 2 | Operand A select: 00 register, 10 execute/memory, 01 write-back |
| fwd_b | output | 2 | Operand B select, same encoding |
| op_a | output | DATA_W | Selected first ALU operand |
| op_b | output | DATA_W | Selected second ALU operand |

## Verification
The assertions assume that every input is a known value on each rising edge. They also assume that `wb_wen` is low while reset is held, so that no write is in progress when the register-file history checks start. The stimulus changes inputs only on falling edges and drives all of them to zero during reset. Random register numbers are drawn from a small range so that matches, double matches and register zero come up often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   // Operand select encoding, shared by the selectors and the multiplexers
   localparam logic [1:0] SEL_RF   = 2'b00;
   localparam logic [1:0] SEL_WB   = 2'b01;
   localparam logic [1:0] SEL_MEM  = 2'b10;
   localparam logic [1:0] SEL_RSVD = 2'b11;
endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 32,
   parameter int ADDR_W  = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [ADDR_W-1:0] ra0,
   input  logic [ADDR_W-1:0] ra1,
   output logic [DATA_W-1:0] rd0,
   output logic [DATA_W-1:0] rd1
);
   if (REG_CNT != (1 << ADDR_W)) begin : g_cnt_chk
      $error("fwd_regfile: REG_CNT must be a power of two");
   end

   logic [DATA_W-1:0] mem [REG_CNT];
   logic              wr_live;

   assign wr_live = we && (wa != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_CNT; i++) mem[i] <= '0;
      end else if (wr_live) begin
         mem[wa] <= wd;
      end
   end

   // Read with same-cycle write bypass; entry zero is constant
   function automatic logic [DATA_W-1:0] rd_port(input logic [ADDR_W-1:0] ra,
                                                 input logic [DATA_W-1:0] stored);
      if (ra == '0)                  return '0;
      else if (wr_live && wa == ra)  return wd;
      else                           return stored;
   endfunction

   assign rd0 = rd_port(ra0, mem[ra0]);
   assign rd1 = rd_port(ra1, mem[ra1]);

   // R9
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ra0 == '0) |-> (rd0 == '0));

   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we) && $past(wa) != '0 && ra1 == $past(wa) && !(we && wa == ra1))
         |-> (rd1 == $past(wd)));
endmodule

// File: rtl/fwd_select.sv
module fwd_select
   import fwd_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] src,
   input  logic              mem_wen,
   input  logic [ADDR_W-1:0] mem_rd,
   input  logic              wb_wen,
   input  logic [ADDR_W-1:0] wb_rd,
   output logic [1:0]        sel
);
   logic mem_hit, wb_hit;

   assign mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
   assign wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);

   // Nearest stage first
   always_comb begin
      if (mem_hit)     sel = SEL_MEM;
      else if (wb_hit) sel = SEL_WB;
      else             sel = SEL_RF;
   end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
   import fwd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] op
);
   always_comb begin
      case (sel)
         SEL_MEM: op = mem_val;
         SEL_WB:  op = wb_val;
         default: op = rf_val;   // register value, also for the unused code
      endcase
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 32,
   parameter int ADDR_W  = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rf_rdata_a,
   output logic [DATA_W-1:0] rf_rdata_b,
   input  logic [ADDR_W-1:0] ex_rs,
   input  logic [ADDR_W-1:0] ex_rt,
   input  logic [DATA_W-1:0] ex_rs_val,
   input  logic [DATA_W-1:0] ex_rt_val,
   input  logic              mem_wen,
   input  logic [ADDR_W-1:0] mem_rd,
   input  logic [DATA_W-1:0] mem_alu,
   input  logic              wb_wen,
   input  logic [ADDR_W-1:0] wb_rd,
   input  logic [DATA_W-1:0] wb_val,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic [DATA_W-1:0] op_a,
   output logic [DATA_W-1:0] op_b
);
   localparam int LANES = 2;

   if (DATA_W < 1) begin : g_dw_chk
      $error("fwd_unit: DATA_W must be positive");
   end
   if (REG_CNT < 2) begin : g_rc_chk
      $error("fwd_unit: REG_CNT must be at least 2");
   end

   fwd_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .ADDR_W(ADDR_W)) rf_i (
      .clk(clk), .rst_n(rst_n),
      .we(wb_wen), .wa(wb_rd), .wd(wb_val),
      .ra0(rd_addr_a), .ra1(rd_addr_b),
      .rd0(rf_rdata_a), .rd1(rf_rdata_b)
   );

   logic [ADDR_W-1:0] lane_src [LANES];
   logic [DATA_W-1:0] lane_val [LANES];
   logic [1:0]        lane_sel [LANES];
   logic [DATA_W-1:0] lane_op  [LANES];

   assign lane_src[0] = ex_rs;
   assign lane_src[1] = ex_rt;
   assign lane_val[0] = ex_rs_val;
   assign lane_val[1] = ex_rt_val;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      fwd_select #(.ADDR_W(ADDR_W)) sel_i (
         .src(lane_src[g]),
         .mem_wen(mem_wen), .mem_rd(mem_rd),
         .wb_wen(wb_wen),   .wb_rd(wb_rd),
         .sel(lane_sel[g])
      );
      fwd_opmux #(.DATA_W(DATA_W)) mux_i (
         .sel(lane_sel[g]),
         .rf_val(lane_val[g]), .mem_val(mem_alu), .wb_val(wb_val),
         .op(lane_op[g])
      );
   end

   assign fwd_a = lane_sel[0];
   assign fwd_b = lane_sel[1];
   assign op_a  = lane_op[0];
   assign op_b  = lane_op[1];

   // R10
   no_rsvd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_a != SEL_RSVD);
   // R10
   no_rsvd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_b != SEL_RSVD);
   // R2
   mem_path_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a == SEL_MEM) |-> (op_a == mem_alu));
   // R3
   wb_path_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_b == SEL_WB) |-> (op_b == wb_val));
   // R4
   no_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wen && !wb_wen) |-> (fwd_a == SEL_RF && op_a == ex_rs_val));
   // R5
   zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd == '0 && wb_rd == '0) |-> (fwd_b == SEL_RF && op_b == ex_rt_val));
   // R6
   near_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen && wb_wen && mem_rd == ex_rs && wb_rd == ex_rs && ex_rs != '0)
         |-> (fwd_a == SEL_MEM));
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;
   localparam int DW = 32;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0;
   logic [DW-1:0] rf_rdata_a, rf_rdata_b;
   logic [AW-1:0] ex_rs = '0, ex_rt = '0;
   logic [DW-1:0] ex_rs_val = '0, ex_rt_val = '0;
   logic          mem_wen = 1'b0;
   logic [AW-1:0] mem_rd = '0;
   logic [DW-1:0] mem_alu = '0;
   logic          wb_wen = 1'b0;
   logic [AW-1:0] wb_rd = '0;
   logic [DW-1:0] wb_val = '0;
   logic [1:0]    fwd_a, fwd_b;
   logic [DW-1:0] op_a, op_b;

   always #2 clk = ~clk;   // 250 MHz

   fwd_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
      .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
      .mem_wen(mem_wen), .mem_rd(mem_rd), .mem_alu(mem_alu),
      .wb_wen(wb_wen), .wb_rd(wb_rd), .wb_val(wb_val),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .op_a(op_a), .op_b(op_b)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] shadow [32];

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_sel(input logic [AW-1:0] src);
      if (mem_wen && mem_rd != 0 && mem_rd == src) return 2'b10;
      if (wb_wen && wb_rd != 0 && wb_rd == src)    return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [DW-1:0] exp_op(input logic [1:0] s, input logic [DW-1:0] v);
      case (s)
         2'b10:   return mem_alu;
         2'b01:   return wb_val;
         default: return v;
      endcase
   endfunction

   function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] ra);
      if (ra == 0) return '0;
      if (wb_wen && wb_rd == ra) return wb_val;
      return shadow[ra];
   endfunction

   function automatic string lane_tag(input logic [AW-1:0] src);
      if (mem_wen && wb_wen && mem_rd == src && wb_rd == src && src != 0) return "R6";
      case (exp_sel(src))
         2'b10:   return "R2";
         2'b01:   return "R3";
         default: return "R1";
      endcase
   endfunction

   // Checks all outputs for the currently driven inputs, then commits the write to the model
   task automatic check_all(input string tag_a, input string tag_b);
      logic [1:0] ea, eb;
      #1;
      ea = exp_sel(ex_rs);
      eb = exp_sel(ex_rt);
      check(fwd_a == ea, tag_a, DW'(fwd_a), DW'(ea));
      check(op_a == exp_op(ea, ex_rs_val), tag_a, op_a, exp_op(ea, ex_rs_val));
      check(fwd_b == eb, tag_b, DW'(fwd_b), DW'(eb));
      check(op_b == exp_op(eb, ex_rt_val), tag_b, op_b, exp_op(eb, ex_rt_val));
      check(fwd_a != 2'b11 && fwd_b != 2'b11, "R10", DW'({fwd_a, fwd_b}), '0);
      check(rf_rdata_a == exp_rd(rd_addr_a), "R8", rf_rdata_a, exp_rd(rd_addr_a));
      check(rf_rdata_b == exp_rd(rd_addr_b), "R9", rf_rdata_b, exp_rd(rd_addr_b));
      if (wb_wen && wb_rd != 0) shadow[wb_rd] = wb_val;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 32; i++) shadow[i] = '0;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R11: every register reads zero after reset
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         rd_addr_a = AW'(i);
         rd_addr_b = AW'(31 - i);
         #1;
         check(rf_rdata_a == '0 && rf_rdata_b == '0, "R11", rf_rdata_a | rf_rdata_b, '0);
      end

      // R1: no writers pending
      @(negedge clk);
      ex_rs = 5'd3; ex_rt = 5'd4; ex_rs_val = 32'h1111; ex_rt_val = 32'h2222;
      mem_alu = 32'hAAAA; wb_val = 32'hBBBB;
      check_all("R1", "R1");

      // R4: matching destinations with write enables low
      @(negedge clk);
      mem_wen = 1'b0; mem_rd = 5'd3; wb_wen = 1'b0; wb_rd = 5'd4;
      check_all("R4", "R4");

      // R5: destination zero with enables high, sources zero
      @(negedge clk);
      ex_rs = 5'd0; ex_rt = 5'd0; mem_wen = 1'b1; mem_rd = 5'd0; wb_wen = 1'b1; wb_rd = 5'd0;
      wb_val = 32'hDEAD_0000;
      check_all("R5", "R5");

      // R9: register 0 not changed by that write, read next cycle
      @(negedge clk);
      wb_wen = 1'b0; rd_addr_a = 5'd0; rd_addr_b = 5'd0;
      check_all("R9", "R9");

      // R6: both stages target rs; R7: only memory stage targets rt lane? no, rt differs
      @(negedge clk);
      ex_rs = 5'd7; ex_rt = 5'd8; mem_wen = 1'b1; mem_rd = 5'd7; wb_wen = 1'b1; wb_rd = 5'd7;
      mem_alu = 32'hC0DE_0001; wb_val = 32'hC0DE_0002;
      check_all("R6", "R7");

      // R3: write-back only on rs, R7: execute/memory only on rt
      @(negedge clk);
      mem_rd = 5'd8; wb_rd = 5'd7;
      check_all("R3", "R7");

      // R8: same-cycle bypass on register 9, then held value
      @(negedge clk);
      mem_wen = 1'b0; wb_wen = 1'b1; wb_rd = 5'd9; wb_val = 32'h0BAD_F00D;
      rd_addr_a = 5'd9; rd_addr_b = 5'd9;
      check_all("R8", "R8");
      @(negedge clk);
      wb_wen = 1'b0; wb_val = 32'h0;
      #1;
      check(rf_rdata_a == 32'h0BAD_F00D, "R8", rf_rdata_a, 32'h0BAD_F00D);
      check_all("R1", "R1");

      // Random traffic on a narrow register range
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         ex_rs     = AW'($urandom_range(0, 3));
         ex_rt     = AW'($urandom_range(0, 3));
         ex_rs_val = $urandom;
         ex_rt_val = $urandom;
         mem_wen   = 1'($urandom_range(0, 1));
         mem_rd    = AW'($urandom_range(0, 3));
         mem_alu   = $urandom;
         wb_wen    = 1'($urandom_range(0, 1));
         wb_rd     = AW'($urandom_range(0, 3));
         wb_val    = $urandom;
         rd_addr_a = AW'($urandom_range(0, 3));
         rd_addr_b = AW'($urandom_range(0, 3));
         check_all(lane_tag(ex_rs), lane_tag(ex_rt));
      end

      finish_run();
   end
endmodule